// File: doc/BRIEF.md
# Posted Read Result Buffer

This block sits in the data path of a serial-wire debug port and handles reads from an access port, where each read is posted. An access-port read request returns the result captured by the previous downstream read, and it also launches a new downstream read. The debugger collects the last outstanding result with a read-buffer request, which launches nothing.

A resend request replays the value that was last delivered, so a reply corrupted on the wire can be recovered without touching the downstream bus again. While a downstream read is outstanding, further access-port and read-buffer requests get a WAIT reply and must be retried. Resend requests are always answered.

An abort input cancels the outstanding transaction and invalidates the buffer. Downstream errors raise a sticky flag, and a status output reports whether the latest completed read was OK. Serial framing is handled elsewhere. Requests arrive one per cycle as decoded codes, and every reply is a registered one-cycle pulse.

Top module: `posted_read_buf`

## Requirements
- R1: Synchronous active-high reset clears every output to zero, empties the buffer (invalid) and clears the replay register to zero.
- R2: An access-port read (req_kind 2'b00) accepted while stall is low answers on the next cycle with rsp_valid=1, rsp_wait=0 and the buffered value. In that same cycle ds_start pulses for exactly one cycle and stall goes high.
- R3: An access-port or read-buffer request (req_kind 2'b00 or 2'b01) made while stall is high answers with rsp_valid=1, rsp_wait=1 and rsp_data=0. It starts nothing and changes no buffer or replay state.
- R4: A completion (ds_done while stall is high) stores ds_data as the buffered value, marks it valid and lowers stall on the next cycle. A read-buffer request (req_kind 2'b01) then returns that value and does not pulse ds_start.
- R5: Each delivered access-port or read-buffer reply consumes the buffer. A reply taken from an invalid buffer carries rsp_data=0 and rsp_stale=1.
- R6: A resend request (req_kind 2'b10) returns the replay register with rsp_wait=0, also while stall is high. It can be repeated with the same result.
- R7: The replay register is loaded only with the value delivered by a non-WAIT access-port or read-buffer reply. Completions, WAIT replies and resends leave it unchanged.
- R8: A completion with ds_err=1 sets sticky_err, which holds until reset. read_ok is set to the inverse of ds_err at each completion.
- R9: abort lowers stall on the next cycle and invalidates the buffer. A request in the same cycle gets no reply, and a later ds_done for the cancelled read is ignored.
- R10: The reserved request code 2'b11 produces no reply and no ds_start.
- R11: ds_done while stall is low has no effect on the buffer or on stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 00 access-port read, 01 read-buffer, 10 resend, 11 reserved |
| abort | input | 1 | Cancel the outstanding downstream read |
| ds_start | output | 1 | One-cycle pulse launching a downstream read |
| ds_done | input | 1 | Downstream read completes this cycle |
| ds_data | input | DW | Downstream read data |
| ds_err | input | 1 | Downstream read ended in error |
| stall | output | 1 | Downstream read outstanding |
| rsp_valid | output | 1 | Reply present this cycle |
| rsp_wait | output | 1 | Reply is WAIT; retry the request |
| rsp_data | output | DW | Reply data |
| rsp_stale | output | 1 | Reply came from an invalid buffer (data forced to zero) |
| sticky_err | output | 1 | A downstream error has occurred since reset |
| read_ok | output | 1 | The latest completed downstream read was OK |

## Verification
The bound checker watches these rules on every cycle:
- ds_start is a single-cycle pulse, and stall is high whenever it fires.
- Access-port and read-buffer requests made under stall always get an empty WAIT reply and never launch.
- Abort empties both stall and the reply.
- The reserved code is silent.
- Stale replies carry zero.
- sticky_err never falls, and an erroring completion sets it.

The pipelining itself can only be shown by the bench's directed sequences:
- data appearing one request late;
- the buffer being consumed and then turning stale;
- the replay register changing only on delivered replies;
- completions being dropped after an abort or when nothing is outstanding.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic [1:0] {
    REQ_AP     = 2'b00,
    REQ_BUF    = 2'b01,
    REQ_RESEND = 2'b10,
    REQ_NONE   = 2'b11
  } req_kind_e;
endpackage

// File: rtl/prb_tracker.sv
// Tracks the single outstanding downstream read and its status flags.
module prb_tracker (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic launch,
  input  logic ds_done,
  input  logic ds_err,
  output logic busy,
  output logic ds_start,
  output logic cpl,
  output logic sticky_err,
  output logic read_ok
);
  assign cpl = busy & ds_done & ~abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      ds_start   <= 1'b0;
      sticky_err <= 1'b0;
      read_ok    <= 1'b0;
    end else begin
      ds_start <= launch;
      if (abort)       busy <= 1'b0;
      else if (launch) busy <= 1'b1;
      else if (cpl)    busy <= 1'b0;
      if (cpl) begin
        sticky_err <= sticky_err | ds_err;
        read_ok    <= ~ds_err;
      end
    end
  end
endmodule

// File: rtl/prb_store.sv
// Holds the posted result, its valid flag and the replay copy.
module prb_store #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          cpl,
  input  logic [DW-1:0] cpl_data,
  input  logic          consume,
  output logic [DW-1:0] deliver_data,
  output logic          deliver_stale,
  output logic [DW-1:0] replay_data
);
  logic [DW-1:0] held_q;
  logic          held_vld_q;

  assign deliver_data  = held_vld_q ? held_q : '0;
  assign deliver_stale = ~held_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q      <= '0;
      held_vld_q  <= 1'b0;
      replay_data <= '0;
    end else begin
      if (abort) begin
        held_vld_q <= 1'b0;
      end else if (cpl) begin
        held_q     <= cpl_data;
        held_vld_q <= 1'b1;
      end else if (consume) begin
        held_vld_q <= 1'b0;
      end
      if (consume) replay_data <= deliver_data;
    end
  end
endmodule

// File: rtl/posted_read_buf.sv
module posted_read_buf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          abort,
  output logic          ds_start,
  input  logic          ds_done,
  input  logic [DW-1:0] ds_data,
  input  logic          ds_err,
  output logic          stall,
  output logic          rsp_valid,
  output logic          rsp_wait,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_stale,
  output logic          sticky_err,
  output logic          read_ok
);
  import prb_pkg::*;

  req_kind_e     kind;
  logic          live, is_post, acc_ap, acc_buf, want_wait, want_resend, consume, cpl;
  logic [DW-1:0] deliver_data, replay_data;
  logic          deliver_stale;

  assign kind        = req_kind_e'(req_kind);
  assign live        = req_valid & ~abort;
  assign is_post     = (kind == REQ_AP) | (kind == REQ_BUF);
  assign acc_ap      = live & ~stall & (kind == REQ_AP);
  assign acc_buf     = live & ~stall & (kind == REQ_BUF);
  assign want_wait   = live & stall & is_post;
  assign want_resend = live & (kind == REQ_RESEND);
  assign consume     = acc_ap | acc_buf;

  prb_tracker u_trk (
    .clk        (clk),
    .rst        (rst),
    .abort      (abort),
    .launch     (acc_ap),
    .ds_done    (ds_done),
    .ds_err     (ds_err),
    .busy       (stall),
    .ds_start   (ds_start),
    .cpl        (cpl),
    .sticky_err (sticky_err),
    .read_ok    (read_ok)
  );

  prb_store #(.DW(DW)) u_st (
    .clk           (clk),
    .rst           (rst),
    .abort         (abort),
    .cpl           (cpl),
    .cpl_data      (ds_data),
    .consume       (consume),
    .deliver_data  (deliver_data),
    .deliver_stale (deliver_stale),
    .replay_data   (replay_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_wait  <= 1'b0;
      rsp_data  <= '0;
      rsp_stale <= 1'b0;
    end else begin
      rsp_valid <= consume | want_wait | want_resend;
      rsp_wait  <= want_wait;
      rsp_stale <= consume & deliver_stale;
      if (consume)          rsp_data <= deliver_data;
      else if (want_resend) rsp_data <= replay_data;
      else                  rsp_data <= '0;
    end
  end
endmodule

// File: rtl/prb_checker.sv
module prb_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    req_kind,
  input logic          abort,
  input logic          ds_start,
  input logic          ds_done,
  input logic          ds_err,
  input logic          stall,
  input logic          rsp_valid,
  input logic          rsp_wait,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_stale,
  input logic          sticky_err
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ds_start |=> !ds_start);
  assert_start_stalls_R2: assert property (@(posedge clk) disable iff (rst)
    ds_start |-> stall);
  assert_wait_when_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_kind[1] && stall && !abort) |=> (rsp_valid && rsp_wait && !ds_start));
  assert_wait_empty_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_wait |-> (rsp_valid && rsp_data == '0 && !rsp_stale));
  assert_stale_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_stale |-> (rsp_valid && !rsp_wait && rsp_data == '0));
  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (rst)
    sticky_err |=> sticky_err);
  assert_err_sets_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (stall && ds_done && ds_err && !abort) |=> sticky_err);
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!stall && !rsp_valid && !ds_start));
  assert_reserved_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b11) |=> (!rsp_valid && !ds_start));
endmodule

bind posted_read_buf prb_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .abort      (abort),
  .ds_start   (ds_start),
  .ds_done    (ds_done),
  .ds_err     (ds_err),
  .stall      (stall),
  .rsp_valid  (rsp_valid),
  .rsp_wait   (rsp_wait),
  .rsp_data   (rsp_data),
  .rsp_stale  (rsp_stale),
  .sticky_err (sticky_err)
);

// File: tb/sim_posted_read_buf.sv
`timescale 1ns/1ps
module sim_posted_read_buf;
  localparam int DW = 32;
  localparam logic [1:0] K_AP = 2'b00, K_BUF = 2'b01, K_RSD = 2'b10, K_RSV = 2'b11;

  logic clk = 1'b0;
  logic rst, req_valid, abort, ds_done, ds_err;
  logic [1:0] req_kind;
  logic [DW-1:0] ds_data;
  logic ds_start, stall, rsp_valid, rsp_wait, rsp_stale, sticky_err, read_ok;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  posted_read_buf #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .abort(abort),
    .ds_start(ds_start), .ds_done(ds_done), .ds_data(ds_data), .ds_err(ds_err),
    .stall(stall), .rsp_valid(rsp_valid), .rsp_wait(rsp_wait), .rsp_data(rsp_data),
    .rsp_stale(rsp_stale), .sticky_err(sticky_err), .read_ok(read_ok)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got %0d cycles, expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one request, sampled one edge later, then removed
  task automatic req(input logic [1:0] k);
    req_valid = 1'b1; req_kind = k;
    step();
    req_valid = 1'b0; req_kind = K_RSV;
  endtask

  task automatic finish_ds(input logic [DW-1:0] d, input logic e);
    ds_done = 1'b1; ds_data = d; ds_err = e;
    step();
    ds_done = 1'b0; ds_data = '0; ds_err = 1'b0;
  endtask

  task automatic reply(input string tag, input logic [DW-1:0] d, input logic stale);
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " rsp_wait"}, rsp_wait, 0);
    chk({tag, " rsp_data"}, rsp_data, d);
    chk({tag, " rsp_stale"}, rsp_stale, stale);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 rsp_data", rsp_data, 0);
    chk("R1 stall", stall, 0);
    chk("R1 ds_start", ds_start, 0);
    chk("R1 sticky_err", sticky_err, 0);
    chk("R1 read_ok", read_ok, 0);
    req(K_RSD);
    reply("R1 replay reset", 0, 0);
  endtask

  task automatic t_first_ap();
    req(K_AP);
    reply("R2/R5 first AP", 0, 1);
    chk("R2 ds_start", ds_start, 1);
    chk("R2 stall", stall, 1);
    step();
    chk("R2 ds_start pulse ends", ds_start, 0);
    chk("R2 stall held", stall, 1);
  endtask

  task automatic t_wait();
    req(K_AP);
    chk("R3 AP wait", rsp_wait, 1);
    chk("R3 AP wait data", rsp_data, 0);
    chk("R3 AP no start", ds_start, 0);
    req(K_BUF);
    chk("R3 BUF wait", rsp_wait, 1);
    req(K_RSD);
    reply("R6 resend while stall", 0, 0);
  endtask

  task automatic t_complete();
    finish_ds(32'hA5A5_0001, 1'b0);
    chk("R4 stall low", stall, 0);
    chk("R8 read_ok", read_ok, 1);
    chk("R8 sticky clear", sticky_err, 0);
    req(K_RSD);
    reply("R7 completion leaves replay", 0, 0);
    req(K_BUF);
    reply("R4 BUF returns result", 32'hA5A5_0001, 0);
    chk("R4 BUF no start", ds_start, 0);
    chk("R4 BUF no stall", stall, 0);
    req(K_RSD);
    reply("R6 resend 1", 32'hA5A5_0001, 0);
    req(K_RSD);
    reply("R6 resend 2", 32'hA5A5_0001, 0);
  endtask

  task automatic t_double_buf();
    req(K_BUF);
    reply("R5 second BUF stale", 0, 1);
    req(K_RSD);
    reply("R7 replay follows stale BUF", 0, 0);
  endtask

  task automatic t_pipeline();
    req(K_AP);
    reply("R2 AP on empty", 0, 1);
    finish_ds(32'h0000_B00B, 1'b0);
    req(K_AP);
    reply("R2 AP returns previous", 32'h0000_B00B, 0);
    chk("R2 AP launches", ds_start, 1);
    finish_ds(32'h0C0C_0C0C, 1'b0);
    req(K_BUF);
    reply("R4 drain last", 32'h0C0C_0C0C, 0);
    req(K_RSD);
    reply("R6 replay drained", 32'h0C0C_0C0C, 0);
  endtask

  task automatic t_error();
    req(K_AP);
    finish_ds(32'hDEAD_0D0D, 1'b1);
    chk("R8 sticky set", sticky_err, 1);
    chk("R8 read_ok low", read_ok, 0);
    req(K_BUF);
    reply("R8 error data buffered", 32'hDEAD_0D0D, 0);
    req(K_AP);
    finish_ds(32'h0000_00EE, 1'b0);
    chk("R8 read_ok recovers", read_ok, 1);
    chk("R8 sticky holds", sticky_err, 1);
    req(K_BUF);
    reply("R8 later data", 32'h0000_00EE, 0);
  endtask

  task automatic t_abort();
    req(K_AP);
    chk("R9 stall before abort", stall, 1);
    abort = 1'b1; req_valid = 1'b1; req_kind = K_BUF;
    step();
    abort = 1'b0; req_valid = 1'b0; req_kind = K_RSV;
    chk("R9 no reply on abort", rsp_valid, 0);
    chk("R9 stall cleared", stall, 0);
    finish_ds(32'h0000_0FFF, 1'b0);
    chk("R11 late done no stall", stall, 0);
    req(K_BUF);
    reply("R9/R11 buffer invalid", 0, 1);
  endtask

  task automatic t_spurious();
    finish_ds(32'h1234_5678, 1'b1);
    chk("R11 idle done sticky unchanged", sticky_err, 1);
    req(K_AP);
    reply("R11 idle done not stored", 0, 1);
    finish_ds(32'h0000_0777, 1'b0);
  endtask

  task automatic t_reserved();
    req(K_RSV);
    chk("R10 no reply", rsp_valid, 0);
    chk("R10 no start", ds_start, 0);
    chk("R10 no stall", stall, 0);
    req(K_BUF);
    reply("R10 buffer untouched", 32'h0000_0777, 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_kind = K_RSV; abort = 1'b0;
    ds_done = 1'b0; ds_data = '0; ds_err = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_first_ap();
    t_wait();
    t_complete();
    t_double_buf();
    t_pipeline();
    t_error();
    t_abort();
    t_spurious();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule